// File: doc/BRIEF.md
# Branch and Compare Unit

This block decides where a 32-bit in-order core fetches next. Each cycle it takes the address of the instruction being executed, a decoded operation kind, a condition selector and a signed displacement. From these, and from three pieces of state it owns (a three-bit compare result, a count register and a link register), it produces the next fetch address and a flag that says whether control flow was redirected. Fetch, decode and the general register file are outside the block; the core hands it operand values that have already been read.

The state changes only at a clock edge. Compare operations write the compare result. Decrement-and-branch writes the count register. Branch-and-link writes the link register. Separate move-to ports let the core load either register, and the move-from outputs always show the stored values. When a move-to and a reader of the same register arrive in the same cycle, the reader sees the new value. The next address, the taken flag and the illegal flag are combinational in the current inputs.

Top module: `flow_ctl_unit`

## Requirements
- R1: After reset the compare result (`flags_o`), the count register (`cnt_o`) and the link register (`lnk_o`) are all zero.
- R2: With `valid_i` high and `op_i`=1 (compare), at the next edge `flags_o` becomes one-hot with bit 2 = less, bit 1 = greater, bit 0 = equal. It compares `cmp_a_i` with `cmp_b_i`, or with `imm_i` when `cmp_imm_i` is 1. `cmp_signed_i`=1 means two's complement, and the immediate is then sign-extended; `cmp_signed_i`=0 means unsigned, and the immediate is zero-extended. No other operation changes `flags_o`.
- R3: `op_i`=2 (jump) with a displacement that is a multiple of 4 is taken, to `pc_i` plus the sign-extended `disp_i`. A zero displacement targets `pc_i` itself.
- R4: For a relative kind (`op_i` 2, 3, 4 or 5) with `disp_i[1:0]` nonzero, `illegal_o` is 1. The branch is then not taken, `next_pc_o` is `pc_i`+4, and neither the count nor the link register changes.
- R5: `op_i`=3 (conditional) goes to the relative target when the stored flags satisfy `cond_i`: 0 equal, 1 greater, 2 less, 3 less-or-equal, 4 greater-or-equal. Codes 5 to 7 are never taken.
- R6: Whenever `taken_o` is 0, `next_pc_o` equals `pc_i`+4.
- R7: `op_i`=4 (count loop) subtracts 1 from the count register first. The branch is taken to the relative target only if the new value is nonzero. The new value is stored at the edge, and 0 wraps to 0xFFFFFFFF.
- R8: `op_i`=5 (jump-and-link) is taken to the relative target and stores `pc_i`+4 in the link register. For example, a branch at 0x80456124 leaves 0x80456128.
- R9: `op_i`=6 jumps to the link register value and `op_i`=7 jumps to the count register value. Both are always taken.
- R10: `cnt_we_i`/`lnk_we_i` load `cnt_wd_i`/`lnk_wd_i` at the edge. In the same cycle, any reader of that register uses the value being written. A decrement or a link capture in that cycle takes priority over the plain write.
- R11: With `valid_i` low the operation inputs have no effect: not taken, not illegal, `next_pc_o` = `pc_i`+4, and flags unchanged. The move-to ports still act.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation inputs are meaningful this cycle |
| op_i | input | 3 | Operation kind (0 idle, 1 compare, 2 jump, 3 conditional, 4 count loop, 5 jump-and-link, 6 to link, 7 to count) |
| cond_i | input | 3 | Condition selector for conditional branches |
| pc_i | input | 32 | Address of the current instruction |
| disp_i | input | 16 | Signed byte displacement for relative branches |
| cmp_a_i | input | 32 | First compare operand |
| cmp_b_i | input | 32 | Second compare operand (register form) |
| imm_i | input | 16 | Immediate compare operand |
| cmp_imm_i | input | 1 | Use the immediate as the second operand |
| cmp_signed_i | input | 1 | Signed compare when 1, unsigned when 0 |
| cnt_we_i | input | 1 | Move-to count register |
| cnt_wd_i | input | 32 | Value for move-to count |
| lnk_we_i | input | 1 | Move-to link register |
| lnk_wd_i | input | 32 | Value for move-to link |
| next_pc_o | output | 32 | Next fetch address |
| taken_o | output | 1 | Control flow redirected |
| illegal_o | output | 1 | Misaligned relative displacement |
| flags_o | output | 3 | Stored compare result {less, greater, equal} |
| cnt_o | output | 32 | Count register (move-from) |
| lnk_o | output | 32 | Link register (move-from) |

## Verification
The bench aims at the edge cases where branch logic usually breaks. A count of one must fall through and a count of zero must wrap and loop; a design that tested the count before decrementing would get both wrong. It applies one bit pattern, 0xFFFFFFFD or an immediate of 0xFFFF, under both signed and unsigned compares. The flags must flip between those modes, so confusing sign extension with zero extension shows up at once. It issues move-to and a reader of the same register in one cycle, where a design without forwarding would jump to the stale value. It checks that a misaligned link branch leaves the link register unchanged.

// File: rtl/flow_pkg.sv
package flow_pkg;

  typedef enum logic [2:0] {
    OP_IDLE   = 3'd0,
    OP_CMP    = 3'd1,
    OP_JUMP   = 3'd2,
    OP_JCOND  = 3'd3,
    OP_JDEC   = 3'd4,
    OP_JLINK  = 3'd5,
    OP_TOLINK = 3'd6,
    OP_TOCNT  = 3'd7
  } flow_op_e;

  typedef enum logic [2:0] {
    CC_EQ = 3'd0,
    CC_GT = 3'd1,
    CC_LT = 3'd2,
    CC_LE = 3'd3,
    CC_GE = 3'd4
  } flow_cc_e;

  localparam int FLG_LT = 2;
  localparam int FLG_GT = 1;
  localparam int FLG_EQ = 0;

endpackage

// File: rtl/flow_compare.sv
module flow_compare
  import flow_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_i,
  input  logic [XLEN-1:0]  a_i,
  input  logic [XLEN-1:0]  b_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             use_imm_i,
  input  logic             signed_i,
  output logic [2:0]       flags_q
);

  localparam int PAD = XLEN - IMM_W;

  // Widen the immediate: sign copy for signed mode, zeros for logical mode.
  function automatic logic [XLEN-1:0] widen(input logic [IMM_W-1:0] v, input logic sgn);
    logic fill;
    fill = sgn & v[IMM_W-1];
    return {{PAD{fill}}, v};
  endfunction

  // Rank both operands: flipping the top bit turns a signed order into an unsigned one.
  function automatic logic [2:0] rank(input logic [XLEN-1:0] x, input logic [XLEN-1:0] y,
                                      input logic sgn);
    logic [XLEN-1:0] xr, yr;
    logic [2:0] r;
    xr = {x[XLEN-1] ^ sgn, x[XLEN-2:0]};
    yr = {y[XLEN-1] ^ sgn, y[XLEN-2:0]};
    r = '0;
    if (xr == yr)     r[FLG_EQ] = 1'b1;
    else if (xr < yr) r[FLG_LT] = 1'b1;
    else              r[FLG_GT] = 1'b1;
    return r;
  endfunction

  logic [XLEN-1:0] rhs;
  logic [2:0]      res;

  always_comb begin
    rhs = use_imm_i ? widen(imm_i, signed_i) : b_i;
    res = rank(a_i, rhs, signed_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flags_q <= '0;
    else if (upd_i) flags_q <= res;
  end

endmodule

// File: rtl/flow_sprs.sv
module flow_sprs #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cnt_we_i,
  input  logic [XLEN-1:0] cnt_wd_i,
  input  logic            lnk_we_i,
  input  logic [XLEN-1:0] lnk_wd_i,
  input  logic            dec_fire_i,
  input  logic            link_fire_i,
  input  logic [XLEN-1:0] link_val_i,
  output logic [XLEN-1:0] cnt_q,
  output logic [XLEN-1:0] lnk_q,
  output logic [XLEN-1:0] cnt_fwd,
  output logic [XLEN-1:0] lnk_fwd,
  output logic [XLEN-1:0] cnt_dec
);

  function automatic logic [XLEN-1:0] pick(input logic we, input logic [XLEN-1:0] wd,
                                           input logic [XLEN-1:0] held);
    return we ? wd : held;
  endfunction

  always_comb begin
    cnt_fwd = pick(cnt_we_i, cnt_wd_i, cnt_q);
    lnk_fwd = pick(lnk_we_i, lnk_wd_i, lnk_q);
    cnt_dec = cnt_fwd - XLEN'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (dec_fire_i) cnt_q <= cnt_dec;
    else if (cnt_we_i)   cnt_q <= cnt_wd_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           lnk_q <= '0;
    else if (link_fire_i) lnk_q <= link_val_i;
    else if (lnk_we_i)    lnk_q <= lnk_wd_i;
  end

endmodule

// File: rtl/flow_target.sv
module flow_target
  import flow_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int DISP_W = 16
) (
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [2:0]        cond_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [2:0]        flags_i,
  input  logic [XLEN-1:0]   cnt_fwd_i,
  input  logic [XLEN-1:0]   cnt_dec_i,
  input  logic [XLEN-1:0]   lnk_fwd_i,
  output logic [XLEN-1:0]   seq_pc_o,
  output logic [XLEN-1:0]   next_pc_o,
  output logic              taken_o,
  output logic              illegal_o,
  output logic              dec_fire_o,
  output logic              link_fire_o
);

  localparam int PAD = XLEN - DISP_W;

  function automatic logic [XLEN-1:0] rel_dest(input logic [XLEN-1:0] pc,
                                               input logic [DISP_W-1:0] d);
    return pc + {{PAD{d[DISP_W-1]}}, d};
  endfunction

  function automatic logic cc_hit(input logic [2:0] f, input logic [2:0] cc);
    case (flow_cc_e'(cc))
      CC_EQ:   return f[FLG_EQ];
      CC_GT:   return f[FLG_GT];
      CC_LT:   return f[FLG_LT];
      CC_LE:   return f[FLG_LT] | f[FLG_EQ];
      CC_GE:   return f[FLG_GT] | f[FLG_EQ];
      default: return 1'b0;
    endcase
  endfunction

  flow_op_e        op;
  logic            is_rel;
  logic            go;
  logic [XLEN-1:0] dest;

  always_comb begin
    op          = flow_op_e'(op_i);
    seq_pc_o    = pc_i + XLEN'(4);
    is_rel      = (op == OP_JUMP) || (op == OP_JCOND) || (op == OP_JDEC) || (op == OP_JLINK);
    illegal_o   = valid_i && is_rel && (disp_i[1:0] != 2'b00);
    go          = valid_i && !illegal_o;
    dest        = rel_dest(pc_i, disp_i);
    taken_o     = 1'b0;
    dec_fire_o  = 1'b0;
    link_fire_o = 1'b0;
    if (go) begin
      case (op)
        OP_JUMP:   taken_o = 1'b1;
        OP_JCOND:  taken_o = cc_hit(flags_i, cond_i);
        OP_JDEC: begin
          dec_fire_o = 1'b1;
          taken_o    = (cnt_dec_i != '0);
        end
        OP_JLINK: begin
          taken_o     = 1'b1;
          link_fire_o = 1'b1;
        end
        OP_TOLINK: begin
          taken_o = 1'b1;
          dest    = lnk_fwd_i;
        end
        OP_TOCNT: begin
          taken_o = 1'b1;
          dest    = cnt_fwd_i;
        end
        default: taken_o = 1'b0;
      endcase
    end
    next_pc_o = taken_o ? dest : seq_pc_o;
  end

endmodule

// File: rtl/flow_ctl_unit.sv
module flow_ctl_unit
  import flow_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int DISP_W = 16,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [2:0]        cond_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [XLEN-1:0]   cmp_a_i,
  input  logic [XLEN-1:0]   cmp_b_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              cmp_imm_i,
  input  logic              cmp_signed_i,
  input  logic              cnt_we_i,
  input  logic [XLEN-1:0]   cnt_wd_i,
  input  logic              lnk_we_i,
  input  logic [XLEN-1:0]   lnk_wd_i,
  output logic [XLEN-1:0]   next_pc_o,
  output logic              taken_o,
  output logic              illegal_o,
  output logic [2:0]        flags_o,
  output logic [XLEN-1:0]   cnt_o,
  output logic [XLEN-1:0]   lnk_o
);

  // Named internal events, visible to the bound checker.
  logic            cmp_fire;
  logic            dec_fire;
  logic            link_fire;
  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] cnt_fwd;
  logic [XLEN-1:0] lnk_fwd;
  logic [XLEN-1:0] cnt_dec;

  assign cmp_fire = valid_i && (flow_op_e'(op_i) == OP_CMP);

  flow_compare #(.XLEN(XLEN), .IMM_W(IMM_W)) u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_i     (cmp_fire),
    .a_i       (cmp_a_i),
    .b_i       (cmp_b_i),
    .imm_i     (imm_i),
    .use_imm_i (cmp_imm_i),
    .signed_i  (cmp_signed_i),
    .flags_q   (flags_o)
  );

  flow_sprs #(.XLEN(XLEN)) u_sprs (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_we_i    (cnt_we_i),
    .cnt_wd_i    (cnt_wd_i),
    .lnk_we_i    (lnk_we_i),
    .lnk_wd_i    (lnk_wd_i),
    .dec_fire_i  (dec_fire),
    .link_fire_i (link_fire),
    .link_val_i  (seq_pc),
    .cnt_q       (cnt_o),
    .lnk_q       (lnk_o),
    .cnt_fwd     (cnt_fwd),
    .lnk_fwd     (lnk_fwd),
    .cnt_dec     (cnt_dec)
  );

  flow_target #(.XLEN(XLEN), .DISP_W(DISP_W)) u_tgt (
    .valid_i     (valid_i),
    .op_i        (op_i),
    .cond_i      (cond_i),
    .pc_i        (pc_i),
    .disp_i      (disp_i),
    .flags_i     (flags_o),
    .cnt_fwd_i   (cnt_fwd),
    .cnt_dec_i   (cnt_dec),
    .lnk_fwd_i   (lnk_fwd),
    .seq_pc_o    (seq_pc),
    .next_pc_o   (next_pc_o),
    .taken_o     (taken_o),
    .illegal_o   (illegal_o),
    .dec_fire_o  (dec_fire),
    .link_fire_o (link_fire)
  );

endmodule

// File: rtl/flow_ctl_chk.sv
module flow_ctl_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            valid_i,
  input logic [2:0]      op_i,
  input logic [XLEN-1:0] pc_i,
  input logic            cnt_we_i,
  input logic [XLEN-1:0] cnt_wd_i,
  input logic            lnk_we_i,
  input logic [XLEN-1:0] lnk_wd_i,
  input logic [XLEN-1:0] next_pc_o,
  input logic            taken_o,
  input logic            illegal_o,
  input logic [2:0]      flags_o,
  input logic [XLEN-1:0] cnt_o,
  input logic [XLEN-1:0] lnk_o,
  input logic            cmp_fire,
  input logic            dec_fire,
  input logic            link_fire
);

  assert_flags_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_fire |=> ($countones(flags_o) == 1));

  assert_flags_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_fire |=> $stable(flags_o));

  assert_illegal_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (!taken_o && !dec_fire && !link_fire));

  assert_seq_pc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !taken_o |-> (next_pc_o == pc_i + XLEN'(4)));

  assert_dec_before_test_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_fire |=> (cnt_o == $past(cnt_we_i ? cnt_wd_i : cnt_o) - XLEN'(1)));

  assert_link_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    link_fire |=> (lnk_o == $past(pc_i) + XLEN'(4)));

  assert_to_link_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 3'd6) |-> (taken_o && next_pc_o == (lnk_we_i ? lnk_wd_i : lnk_o)));

  assert_move_cnt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_we_i && !dec_fire) |=> (cnt_o == $past(cnt_wd_i)));

  assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |-> (!taken_o && !illegal_o));

endmodule

bind flow_ctl_unit flow_ctl_chk #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .valid_i   (valid_i),
  .op_i      (op_i),
  .pc_i      (pc_i),
  .cnt_we_i  (cnt_we_i),
  .cnt_wd_i  (cnt_wd_i),
  .lnk_we_i  (lnk_we_i),
  .lnk_wd_i  (lnk_wd_i),
  .next_pc_o (next_pc_o),
  .taken_o   (taken_o),
  .illegal_o (illegal_o),
  .flags_o   (flags_o),
  .cnt_o     (cnt_o),
  .lnk_o     (lnk_o),
  .cmp_fire  (cmp_fire),
  .dec_fire  (dec_fire),
  .link_fire (link_fire)
);

// File: tb/sim_flow_ctl_unit.sv
`timescale 1ns/1ps
module sim_flow_ctl_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0, cond_i = '0;
  logic [31:0] pc_i = '0, cmp_a_i = '0, cmp_b_i = '0, cnt_wd_i = '0, lnk_wd_i = '0;
  logic [15:0] disp_i = '0, imm_i = '0;
  logic        cmp_imm_i = 1'b0, cmp_signed_i = 1'b0, cnt_we_i = 1'b0, lnk_we_i = 1'b0;
  logic [31:0] next_pc_o, cnt_o, lnk_o;
  logic        taken_o, illegal_o;
  logic [2:0]  flags_o;

  always #10 clk = ~clk;

  flow_ctl_unit u0 (.*);

  typedef struct {
    string       tag;
    logic [31:0] npc;
    logic        tk;
    logic        il;
    logic [2:0]  fl;
    logic [31:0] cnt;
    logic [31:0] lnk;
  } item_t;

  item_t sb_q[$];
  event  chk_ev;
  int    n_tests = 0;
  int    n_fail  = 0;

  // Reference state kept by the bench.
  logic [2:0]  m_fl  = '0;
  logic [31:0] m_cnt = '0;
  logic [31:0] m_lnk = '0;

  // Staged stimulus.
  logic        s_v;
  logic [2:0]  s_op, s_cc;
  logic [31:0] s_pc, s_a, s_b, s_cwd, s_lwd;
  logic [15:0] s_d, s_imm;
  logic        s_ui, s_sg, s_cw, s_lw;

  task automatic clr();
    s_v = 1'b1; s_op = 3'd0; s_cc = 3'd0; s_pc = 32'h0000_1000; s_a = '0; s_b = '0;
    s_cwd = '0; s_lwd = '0; s_d = '0; s_imm = '0; s_ui = 1'b0; s_sg = 1'b0;
    s_cw = 1'b0; s_lw = 1'b0;
  endtask

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic fire(string tag);
    item_t it;
    logic [31:0] fc, fk, seq, sd, tgt, ncnt, nlnk, rhs;
    logic [2:0]  nfl;
    logic        rel, ill, tk, less, eq;
    @(negedge clk);
    valid_i = s_v; op_i = s_op; cond_i = s_cc; pc_i = s_pc; disp_i = s_d;
    cmp_a_i = s_a; cmp_b_i = s_b; imm_i = s_imm; cmp_imm_i = s_ui; cmp_signed_i = s_sg;
    cnt_we_i = s_cw; cnt_wd_i = s_cwd; lnk_we_i = s_lw; lnk_wd_i = s_lwd;

    fc   = s_cw ? s_cwd : m_cnt;
    fk   = s_lw ? s_lwd : m_lnk;
    seq  = s_pc + 32'd4;
    sd   = 32'($signed(s_d));
    rel  = s_v && (s_op >= 3'd2) && (s_op <= 3'd5);
    ill  = rel && (s_d[1:0] != 2'b00);
    tk   = 1'b0; tgt = s_pc + sd;
    ncnt = fc; nlnk = fk; nfl = m_fl;
    if (s_v && !ill) begin
      case (s_op)
        3'd1: begin
          if (s_ui) rhs = s_sg ? 32'($signed(s_imm)) : {16'h0, s_imm};
          else      rhs = s_b;
          eq   = (s_a == rhs);
          less = s_sg ? ($signed(s_a) < $signed(rhs)) : (s_a < rhs);
          nfl  = eq ? 3'b001 : (less ? 3'b100 : 3'b010);
        end
        3'd2: tk = 1'b1;
        3'd3: case (s_cc)
                3'd0: tk = m_fl[0];
                3'd1: tk = m_fl[1];
                3'd2: tk = m_fl[2];
                3'd3: tk = m_fl[2] | m_fl[0];
                3'd4: tk = m_fl[1] | m_fl[0];
                default: tk = 1'b0;
              endcase
        3'd4: begin ncnt = fc - 32'd1; tk = (ncnt != 0); end
        3'd5: begin tk = 1'b1; nlnk = seq; end
        3'd6: begin tk = 1'b1; tgt = fk; end
        3'd7: begin tk = 1'b1; tgt = fc; end
        default: tk = 1'b0;
      endcase
    end
    it.tag = tag; it.npc = tk ? tgt : seq; it.tk = tk; it.il = ill;
    it.fl = m_fl; it.cnt = m_cnt; it.lnk = m_lnk;
    sb_q.push_back(it);
    -> chk_ev;
    m_fl = nfl; m_cnt = ncnt; m_lnk = nlnk;
  endtask

  // Monitor: pops one expected item per issued operation.
  initial begin
    item_t it;
    forever begin
      @(chk_ev);
      #3;
      it = sb_q.pop_front();
      check(it.tag, "next_pc", next_pc_o, it.npc);
      check(it.tag, "taken",   32'(taken_o), 32'(it.tk));
      check(it.tag, "illegal", 32'(illegal_o), 32'(it.il));
      check(it.tag, "flags",   32'(flags_o), 32'(it.fl));
      check(it.tag, "count",   cnt_o, it.cnt);
      check(it.tag, "link",    lnk_o, it.lnk);
    end
  end

  initial begin
    #4_000_000;
    n_tests++; n_fail++;
    $display("FAIL R11 watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state, observed with an idle operation
    clr(); s_op = 3'd0; fire("R1");

    // R2: signed register compare 5 vs -3 -> greater
    clr(); s_op = 3'd1; s_sg = 1'b1; s_a = 32'd5; s_b = 32'hFFFF_FFFD; fire("R2");
    clr(); s_op = 3'd3; s_cc = 3'd1; s_d = 16'h0040; fire("R5");
    clr(); s_op = 3'd3; s_cc = 3'd3; s_d = 16'h0040; fire("R5");
    // R2: same pattern, unsigned -> less
    clr(); s_op = 3'd1; s_sg = 1'b0; s_a = 32'd5; s_b = 32'hFFFF_FFFD; fire("R2");
    clr(); s_op = 3'd3; s_cc = 3'd2; s_d = 16'hFFF0; fire("R5");
    clr(); s_op = 3'd3; s_cc = 3'd4; s_d = 16'hFFF0; fire("R5");
    // R2: signed immediate 0xFFFF is -1 -> equal to all-ones
    clr(); s_op = 3'd1; s_sg = 1'b1; s_ui = 1'b1; s_a = 32'hFFFF_FFFF; s_imm = 16'hFFFF; fire("R2");
    clr(); s_op = 3'd3; s_cc = 3'd0; s_d = 16'h0008; fire("R5");
    clr(); s_op = 3'd3; s_cc = 3'd3; s_d = 16'h0008; fire("R5");
    clr(); s_op = 3'd3; s_cc = 3'd7; s_d = 16'h0008; fire("R5");
    // R2: logical immediate zero-extended -> greater
    clr(); s_op = 3'd1; s_sg = 1'b0; s_ui = 1'b1; s_a = 32'hFFFF_FFFF; s_imm = 16'hFFFF; fire("R2");
    clr(); s_op = 3'd3; s_cc = 3'd0; s_d = 16'h0008; fire("R6");
    clr(); s_op = 3'd3; s_cc = 3'd4; s_d = 16'h0008; fire("R5");

    // R3: jumps forward, backward, to self
    clr(); s_op = 3'd2; s_d = 16'h0100; fire("R3");
    clr(); s_op = 3'd2; s_d = 16'hFFF8; fire("R3");
    clr(); s_op = 3'd2; s_d = 16'h0000; fire("R3");
    // R4: misaligned relative forms
    clr(); s_op = 3'd2; s_d = 16'h0006; fire("R4");
    clr(); s_op = 3'd3; s_cc = 3'd1; s_d = 16'h0001; fire("R4");

    // R8: jump-and-link capture
    clr(); s_op = 3'd5; s_pc = 32'h8045_6124; s_d = 16'h1F8C; fire("R8");
    clr(); s_op = 3'd5; s_pc = 32'h0000_2000; s_d = 16'h0012; fire("R4");
    clr(); s_op = 3'd6; fire("R9");

    // R10/R7: load count 3 then loop until fall-through
    clr(); s_op = 3'd0; s_cw = 1'b1; s_cwd = 32'd3; fire("R10");
    clr(); s_op = 3'd4; s_d = 16'hFFFC; fire("R7");
    clr(); s_op = 3'd4; s_d = 16'hFFFC; fire("R7");
    clr(); s_op = 3'd4; s_d = 16'hFFFC; fire("R7");
    clr(); s_op = 3'd4; s_d = 16'hFFFC; fire("R7");
    clr(); s_op = 3'd4; s_d = 16'h0003; fire("R4");
    // R10: forwarded count of 1 meets a loop in the same cycle
    clr(); s_op = 3'd4; s_d = 16'h0020; s_cw = 1'b1; s_cwd = 32'd1; fire("R10");
    // R9/R10: indirect targets with and without forwarding
    clr(); s_op = 3'd7; s_cw = 1'b1; s_cwd = 32'h0000_8000; fire("R10");
    clr(); s_op = 3'd7; fire("R9");
    clr(); s_op = 3'd6; s_lw = 1'b1; s_lwd = 32'h0000_4444; fire("R10");
    clr(); s_op = 3'd6; fire("R9");
    // R10: link capture outranks plain write
    clr(); s_op = 3'd5; s_pc = 32'h0000_3000; s_d = 16'h0010; s_lw = 1'b1; s_lwd = 32'h1234_5678; fire("R10");

    // R11: operations with valid low do nothing
    clr(); s_v = 1'b0; s_op = 3'd2; s_d = 16'h0100; fire("R11");
    clr(); s_v = 1'b0; s_op = 3'd1; s_a = 32'd1; s_b = 32'd9; fire("R11");
    clr(); s_v = 1'b0; s_op = 3'd4; s_d = 16'h0003; fire("R11");
    clr(); s_op = 3'd0; fire("R11");

    @(negedge clk);
    #5;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule